// File: doc/BRIEF.md
# Framed SPI Slave with Data and Status Channels

This block is an SPI slave, mode 0, MSB first. Each time the master pulls select low it exchanges exactly one 16-bit frame. The first byte the master sends is a channel code. The second byte is the payload. The channel code sends the payload either to the user-data channel or to the status channel, so every transaction carries one useful byte for each 16 clocks.

All three SPI inputs pass through two-flop synchronizers into the system clock, and SCK edges are found in that domain. The SCK rate must therefore be well below the system clock rate. On the fabric side the block holds one outgoing byte per channel. Both bytes are captured by a load strobe, but only while the master is not selecting the slave. The block returns the received payload and the channel that was addressed, plus a one-cycle completion pulse or a one-cycle error pulse. The MISO pad is driven only while selected. Otherwise the output enable is low, so the line can be shared with other slaves.

The slave shifts the status byte out while the channel code arrives. It then shifts out the byte of the channel that the code named.

Top module: `spi_frame_slave`

## Requirements
- R1: After reset, frame_done, frame_err, spi_miso_oe, rx_payload and rx_chan are all 0.
- R2: With select low, the first 8 rising SCK edges sample a channel code and the next 8 sample a payload, both MSB first. After the 16th rising edge, frame_done pulses for exactly one clock and rx_payload holds the payload byte.
- R3: A channel code of 0x00 sets rx_chan to 0 (user data) and a code of 0x01 sets rx_chan to 1 (status), both reported with frame_done.
- R4: Any other channel code gives a one-cycle frame_err pulse and no frame_done, and rx_payload and rx_chan keep their previous values.
- R5: If select is released before the 16th rising edge, neither pulse appears and the outputs keep their values. The next complete frame is handled normally.
- R6: During the channel-code byte, spi_miso presents the stored status byte MSB first. The first bit is valid before the first rising edge, and each following bit changes after a falling edge.
- R7: During the payload byte, spi_miso presents the stored user-data byte for code 0x00, the stored status byte for code 0x01, and 0x00 for any other code.
- R8: spi_miso_oe is high only while select is low. It falls within a few system clocks after select is released.
- R9: tx_load copies tx_data and tx_status into the stored bytes only while select is released. A strobe during a frame has no effect on what later frames shift out.
- R10: Rising edges after the 16th in one select window are ignored. There is one frame_done at most per select window, and the reported payload is the second byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI clock from master (idle low) |
| spi_cs_n | input | 1 | Slave select, active low |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_oe | output | 1 | Pad enable for spi_miso; pad is high impedance when low |
| tx_load | input | 1 | Strobe that captures both outgoing bytes |
| tx_data | input | BYTE_W | Outgoing user-data byte |
| tx_status | input | BYTE_W | Outgoing status byte |
| rx_payload | output | BYTE_W | Last accepted payload byte |
| rx_chan | output | 1 | Channel of last accepted payload (0 data, 1 status) |
| frame_done | output | 1 | One-cycle pulse for a completed valid frame |
| frame_err | output | 1 | One-cycle pulse for a completed frame with an unknown channel code |

## Verification
The bench targets the moment when the outgoing byte switches from status to the addressed channel. A design that switches one edge late or early corrupts the first payload bit the master reads. It sends an unknown channel code and expects no completion pulse and an unchanged payload, which catches a design that lets the discarded byte through. It cuts a frame short after 11 bits, which exposes a counter that is not cleared on release. It also keeps clocking past 16 bits, which shows a design that wraps into a second frame. It strobes new outgoing bytes in the middle of a frame and then reads them back in later frames, which exposes a load path that ignores the select rule.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

  // channel selector carried in the first byte of a frame
  typedef enum logic {
    CH_DATA   = 1'b0,
    CH_STATUS = 1'b1
  } chan_e;

  localparam int CODE_DATA   = 0;
  localparam int CODE_STATUS = 1;

endpackage

// File: rtl/sfs_sync.sv
module sfs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sfs_tx_bank.sv
module sfs_tx_bank #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              load,
  input  logic [BYTE_W-1:0] data_in,
  input  logic [BYTE_W-1:0] status_in,
  output logic [BYTE_W-1:0] data_q,
  output logic [BYTE_W-1:0] status_q
);
  // bytes may only change while the master has the slave released
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q   <= '0;
      status_q <= '0;
    end else if (load && !sel) begin
      data_q   <= data_in;
      status_q <= status_in;
    end
  end
endmodule

// File: rtl/sfs_rx_framer.sv
module sfs_rx_framer
  import spi_frame_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              sck_rise,
  input  logic              mosi,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              code_ok,
  output chan_e             code_chan,
  output logic              frame_ok,
  output logic              frame_bad,
  output logic [BYTE_W-1:0] payload
);
  localparam int FRAME_BITS = 2 * BYTE_W;
  localparam logic [CNT_W-1:0] LAST_CODE_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] LAST_BIT      = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FULL          = CNT_W'(FRAME_BITS);
  localparam logic [BYTE_W-1:0] CODE_D = BYTE_W'(CODE_DATA);
  localparam logic [BYTE_W-1:0] CODE_S = BYTE_W'(CODE_STATUS);

  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] nxt;

  assign nxt = {shreg[BYTE_W-2:0], mosi};

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt   <= '0;
      shreg     <= '0;
      code_ok   <= 1'b0;
      code_chan <= CH_DATA;
      frame_ok  <= 1'b0;
      frame_bad <= 1'b0;
      payload   <= '0;
    end else begin
      frame_ok  <= 1'b0;
      frame_bad <= 1'b0;
      if (!sel) begin
        bit_cnt <= '0;
      end else if (sck_rise && bit_cnt != FULL) begin
        shreg   <= nxt;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST_CODE_BIT) begin
          code_ok   <= (nxt == CODE_D) || (nxt == CODE_S);
          code_chan <= (nxt == CODE_S) ? CH_STATUS : CH_DATA;
        end
        if (bit_cnt == LAST_BIT) begin
          if (code_ok) begin
            frame_ok <= 1'b1;
            payload  <= nxt;
          end else begin
            frame_bad <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sfs_tx_shifter.sv
module sfs_tx_shifter
  import spi_frame_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              sel_start,
  input  logic              sck_fall,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              code_ok,
  input  chan_e             code_chan,
  input  logic [BYTE_W-1:0] data_q,
  input  logic [BYTE_W-1:0] status_q,
  output logic              miso,
  output logic              miso_oe
);
  localparam logic [CNT_W-1:0] SWITCH_AT = CNT_W'(BYTE_W);

  logic [BYTE_W-1:0] out_sr;
  logic [BYTE_W-1:0] second_byte;

  always_comb begin
    if (!code_ok)                   second_byte = '0;
    else if (code_chan == CH_STATUS) second_byte = status_q;
    else                            second_byte = data_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_sr  <= '0;
      miso_oe <= 1'b0;
    end else begin
      miso_oe <= sel;
      if (sel_start) begin
        out_sr <= status_q;
      end else if (sel && sck_fall) begin
        if (bit_cnt == SWITCH_AT) out_sr <= second_byte;
        else                      out_sr <= {out_sr[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign miso = miso_oe & out_sr[BYTE_W-1];
endmodule

// File: rtl/spi_frame_slave.sv
module spi_frame_slave
  import spi_frame_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic [BYTE_W-1:0] tx_status,
  output logic [BYTE_W-1:0] rx_payload,
  output logic              rx_chan,
  output logic              frame_done,
  output logic              frame_err
);
  localparam int FRAME_BITS = 2 * BYTE_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  logic sck_s, cs_n_s, mosi_s;
  logic sck_q, sel_q;
  logic sel_active, sel_start, sck_rise, sck_fall;

  logic [CNT_W-1:0]  bit_cnt;
  logic              code_ok, frame_ok, frame_bad;
  chan_e             code_chan;
  logic [BYTE_W-1:0] payload;
  logic [BYTE_W-1:0] data_q, status_q;

  sfs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck
    (.clk(clk), .rst(rst), .d(spi_sck),  .q(sck_s));
  sfs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs
    (.clk(clk), .rst(rst), .d(spi_cs_n), .q(cs_n_s));
  sfs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi
    (.clk(clk), .rst(rst), .d(spi_mosi), .q(mosi_s));

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      sck_q <= sck_s;
      sel_q <= sel_active;
    end
  end

  assign sel_active = ~cs_n_s;
  assign sel_start  = sel_active & ~sel_q;
  assign sck_rise   = sck_s & ~sck_q;
  assign sck_fall   = ~sck_s & sck_q;

  sfs_tx_bank #(.BYTE_W(BYTE_W)) u_bank (
    .clk(clk), .rst(rst), .sel(sel_active), .load(tx_load),
    .data_in(tx_data), .status_in(tx_status),
    .data_q(data_q), .status_q(status_q)
  );

  sfs_rx_framer #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_framer (
    .clk(clk), .rst(rst), .sel(sel_active), .sck_rise(sck_rise),
    .mosi(mosi_s), .bit_cnt(bit_cnt), .code_ok(code_ok),
    .code_chan(code_chan), .frame_ok(frame_ok), .frame_bad(frame_bad),
    .payload(payload)
  );

  sfs_tx_shifter #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_shifter (
    .clk(clk), .rst(rst), .sel(sel_active), .sel_start(sel_start),
    .sck_fall(sck_fall), .bit_cnt(bit_cnt), .code_ok(code_ok),
    .code_chan(code_chan), .data_q(data_q), .status_q(status_q),
    .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  // registered fabric-side results
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_payload <= '0;
      rx_chan    <= 1'b0;
      frame_done <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      frame_done <= frame_ok;
      frame_err  <= frame_bad;
      if (frame_ok) begin
        rx_payload <= payload;
        rx_chan    <= (code_chan == CH_STATUS);
      end
    end
  end
endmodule

// File: rtl/spi_frame_slave_chk.sv
module spi_frame_slave_chk #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_active,
  input logic              frame_done,
  input logic              frame_err,
  input logic              miso_oe,
  input logic [BYTE_W-1:0] rx_payload,
  input logic              rx_chan,
  input logic [BYTE_W-1:0] data_q,
  input logic [BYTE_W-1:0] status_q,
  input logic [CNT_W-1:0]  bit_cnt
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(2 * BYTE_W);

  p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  p_err_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(frame_done && frame_err));

  p_payload_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!$stable(rx_payload) || !$stable(rx_chan)) |-> frame_done);

  p_oe_release_r8: assert property (@(posedge clk) disable iff (rst)
    !sel_active |=> !miso_oe);

  p_tx_hold_r9: assert property (@(posedge clk) disable iff (rst)
    sel_active |=> ($stable(data_q) && $stable(status_q)));

  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= FULL);
endmodule

bind spi_frame_slave spi_frame_slave_chk #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .sel_active(sel_active), .frame_done(frame_done),
  .frame_err(frame_err), .miso_oe(spi_miso_oe), .rx_payload(rx_payload),
  .rx_chan(rx_chan), .data_q(data_q), .status_q(status_q), .bit_cnt(bit_cnt)
);

// File: tb/spi_frame_slave_bench.sv
module spi_frame_slave_bench;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe;
  logic tx_load = 1'b0;
  logic [7:0] tx_data = 8'h00, tx_status = 8'h00;
  logic [7:0] rx_payload;
  logic rx_chan, frame_done, frame_err;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int err_cnt = 0;

  always #10 clk = ~clk;

  spi_frame_slave u_spi_frame_slave (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .tx_load(tx_load),
    .tx_data(tx_data), .tx_status(tx_status), .rx_payload(rx_payload),
    .rx_chan(rx_chan), .frame_done(frame_done), .frame_err(frame_err)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (frame_done) done_cnt++;
      if (frame_err)  err_cnt++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic load_bytes(input logic [7:0] d, input logic [7:0] s);
    tx_data = d; tx_status = s; tx_load = 1'b1;
    tick(1);
    tx_load = 1'b0;
    tick(2);
  endtask

  task automatic spi_xfer(input logic [7:0] code, input logic [7:0] pl,
                          input int nbits, input bit mid_load,
                          output logic [15:0] cap, output bit oe_ok);
    logic [15:0] word;
    word = {code, pl};
    cap = '0; oe_ok = 1'b1;
    cs_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? word[15-i] : 1'b0;
      tick(HALF);
      if (i < 16) cap[15-i] = miso;
      if (!miso_oe) oe_ok = 1'b0;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
      if (mid_load && i == 10) begin
        tx_data = 8'hEE; tx_status = 8'hDD; tx_load = 1'b1;
        tick(1);
        tx_load = 1'b0;
      end
    end
    tick(HALF);
    cs_n = 1'b1;
    tick(3 * HALF);
  endtask

  task automatic t_reset();
    chk("R1 frame_done", 16'(frame_done), 16'h0);
    chk("R1 frame_err", 16'(frame_err), 16'h0);
    chk("R1 miso_oe", 16'(miso_oe), 16'h0);
    chk("R1 rx_payload", 16'(rx_payload), 16'h0);
    chk("R1 rx_chan", 16'(rx_chan), 16'h0);
  endtask

  task automatic t_data_frame();
    logic [15:0] cap; bit oe_ok; int d0, e0;
    d0 = done_cnt; e0 = err_cnt;
    spi_xfer(8'h00, 8'hA5, 16, 1'b0, cap, oe_ok);
    chk("R2 done count", 16'(done_cnt - d0), 16'd1);
    chk("R2 rx_payload", 16'(rx_payload), 16'h00A5);
    chk("R3 data chan", 16'(rx_chan), 16'h0);
    chk("R6 R7 miso data", cap, 16'h3C96);
    chk("R8 oe while selected", 16'(oe_ok), 16'h1);
    chk("R8 oe after release", 16'(miso_oe), 16'h0);
    chk("R4 no err on good code", 16'(err_cnt - e0), 16'd0);
  endtask

  task automatic t_status_frame();
    logic [15:0] cap; bit oe_ok; int d0;
    d0 = done_cnt;
    spi_xfer(8'h01, 8'h5A, 16, 1'b0, cap, oe_ok);
    chk("R2 done count status", 16'(done_cnt - d0), 16'd1);
    chk("R3 status payload", 16'(rx_payload), 16'h005A);
    chk("R3 status chan", 16'(rx_chan), 16'h1);
    chk("R7 miso status", cap, 16'h3C3C);
  endtask

  task automatic t_bad_code();
    logic [15:0] cap; bit oe_ok; int d0, e0;
    d0 = done_cnt; e0 = err_cnt;
    spi_xfer(8'h80, 8'hFF, 16, 1'b0, cap, oe_ok);
    chk("R4 err pulse", 16'(err_cnt - e0), 16'd1);
    chk("R4 no done", 16'(done_cnt - d0), 16'd0);
    chk("R4 payload kept", 16'(rx_payload), 16'h005A);
    chk("R4 chan kept", 16'(rx_chan), 16'h1);
    chk("R7 miso bad code", cap, 16'h3C00);
  endtask

  task automatic t_partial();
    logic [15:0] cap; bit oe_ok; int d0, e0;
    d0 = done_cnt; e0 = err_cnt;
    spi_xfer(8'h00, 8'h77, 11, 1'b0, cap, oe_ok);
    chk("R5 no done", 16'(done_cnt - d0), 16'd0);
    chk("R5 no err", 16'(err_cnt - e0), 16'd0);
    chk("R5 payload kept", 16'(rx_payload), 16'h005A);
    spi_xfer(8'h00, 8'h42, 16, 1'b0, cap, oe_ok);
    chk("R5 next frame done", 16'(done_cnt - d0), 16'd1);
    chk("R5 next frame payload", 16'(rx_payload), 16'h0042);
    chk("R5 next frame chan", 16'(rx_chan), 16'h0);
  endtask

  task automatic t_load_rule();
    logic [15:0] cap; bit oe_ok;
    spi_xfer(8'h00, 8'h11, 16, 1'b1, cap, oe_ok);
    spi_xfer(8'h00, 8'h12, 16, 1'b0, cap, oe_ok);
    chk("R9 mid-frame load ignored", cap, 16'h3C96);
    load_bytes(8'h81, 8'h7E);
    spi_xfer(8'h01, 8'h22, 16, 1'b0, cap, oe_ok);
    chk("R9 idle load status", cap, 16'h7E7E);
    spi_xfer(8'h00, 8'h23, 16, 1'b0, cap, oe_ok);
    chk("R9 idle load data", cap, 16'h7E81);
  endtask

  task automatic t_overrun();
    logic [15:0] cap; bit oe_ok; int d0;
    d0 = done_cnt;
    spi_xfer(8'h01, 8'hC3, 24, 1'b0, cap, oe_ok);
    chk("R10 single done", 16'(done_cnt - d0), 16'd1);
    chk("R10 payload second byte", 16'(rx_payload), 16'h00C3);
    chk("R10 chan", 16'(rx_chan), 16'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(5);
    rst = 1'b0;
    tick(2);
    t_reset();
    load_bytes(8'h96, 8'h3C);
    t_data_frame();
    t_status_frame();
    t_bad_code();
    t_partial();
    t_load_rule();
    t_overrun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule